// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-clock static memory with registered inputs and a registered read path. On each rising edge it captures the address, write data, two active-low byte-lane write enables and the access controls, and performs the access internally without any external write pulse. Read data passes through an output pipeline register, so a read sampled on one edge drives the data bus after the next edge. The default depth is small for simulation; setting `ADDR_W` to 15 gives the full 32768 x 18 array.

Two active-low address strobes start an access at the external address: a processor strobe, which always starts a read, and a controller strobe, which starts a read or a write depending on the byte enables. When neither strobe is low the held address is reused, which gives a two-cycle single write: load the address with the processor strobe, then present data and byte enables with both strobes high. The chip enable is sampled only when an address is loaded. The output enable is asynchronous and gates a data output plus a drive flag that stand in for a tri-state bus.

Top module: `pipe_bw_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits; a word written at an address is returned by a later read of that address.
- R2: A read sampled on rising edge k drives its data on `dq_o` with `dq_oe_o` high from rising edge k+1 onward (one pipeline register of latency).
- R3: `byte_we_ni[0]` low writes data bits 8:0 and `byte_we_ni[1]` low writes bits 17:9; a lane whose enable is high keeps its stored value, and both lanes may be written in one cycle.
- R4: With both strobes high the address register holds, so continue cycles (read or write) use the last loaded address and the address input is ignored; a processor-strobe cycle followed by a cycle with both strobes high and a byte enable low writes the data at the loaded address.
- R5: A processor-strobe cycle with the chip enabled is a read regardless of the byte enables, and writes nothing.
- R6: When `chip_en_ni` is high at a strobe cycle the block is deselected: no access takes place in that cycle or in the following continue cycles, and nothing is driven after the next edge.
- R7: `out_en_ni` is not clocked: while it is high `dq_oe_o` is low, and a change of it alters `dq_oe_o` without any clock edge.
- R8: In the cycle after an edge that sampled a write, `dq_oe_o` is low whatever `out_en_ni` is, and the edge after a write or idle access leaves no valid data in the output register.
- R9: While reset is active, and after it until a read has passed the pipeline, `dq_oe_o` is low.
- R10: A read in the cycle right after a write to the same address returns the newly written bytes.
- R11: `dq_o` is zero whenever `dq_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| proc_strb_ni | input | 1 | Processor address strobe, active low, starts a read |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low, starts a read or write |
| chip_en_ni | input | 1 | Chip enable, active low, sampled at strobe cycles |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 18 | Write data |
| byte_we_ni | input | 2 | Active-low lane write enables, bit 0 lower lane, bit 1 upper lane |
| out_en_ni | input | 1 | Asynchronous active-low output enable |
| dq_o | output | 18 | Read data, zero when not driven |
| dq_oe_o | output | 1 | High when the data bus is driven |

## Verification
The hardest situation to reach is a continue cycle that runs on state captured several cycles earlier: the held deselect after a chip-enable-high strobe, and the two-cycle write whose second cycle carries a different, ignored address. The stimulus table walks strobe, continue and deselect cycles in sequence and reads back every affected word later, so a wrongly held address or a write during a deselected continue cycle shows up as wrong data. The output enable is toggled between clock edges while valid data sits in the output register, and reset is dropped in the same state.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              chip_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [LANES-1:0]  byte_we_ni,
  output logic [ADDR_W-1:0] addr_q_o,
  output op_e               op_q_o,
  output logic [LANES-1:0]  lane_we_q_o,
  output logic [DATA_W-1:0] din_q_o
);
  logic load, sel_d, sel_q;
  op_e  op_d;

  assign load  = !proc_strb_ni || !ctrl_strb_ni;
  // chip enable only counts when a new address is loaded
  assign sel_d = load ? !chip_en_ni : sel_q;

  always_comb begin
    if (!sel_d)              op_d = OP_IDLE;
    else if (!proc_strb_ni)  op_d = OP_RD;
    else if (|(~byte_we_ni)) op_d = OP_WR;
    else                     op_d = OP_RD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o    <= '0;
      sel_q       <= 1'b0;
      op_q_o      <= OP_IDLE;
      lane_we_q_o <= '0;
      din_q_o     <= '0;
    end else begin
      if (load) addr_q_o <= addr_i;
      sel_q       <= sel_d;
      op_q_o      <= op_d;
      lane_we_q_o <= ~byte_we_ni;
      din_q_o     <= din_i;
    end
  end

  // R4: continue cycles keep the loaded address
  a_r4_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_strb_ni && ctrl_strb_ni) |=> $stable(addr_q_o));

  // R6: a deselecting strobe produces no access
  a_r6_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni || !ctrl_strb_ni) && chip_en_ni |=> (op_q_o == OP_IDLE));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_outreg.sv
module sram_outreg
  import sram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= (op_i == OP_RD);
      if (op_i == OP_RD) data_q <= rdata_i;
    end
  end

  // output enable is ignored while a write is in progress
  assign drive   = valid_q && !out_en_ni && (op_i != OP_WR);
  assign dq_oe_o = drive;
  assign dq_o    = drive ? data_q : '0;

  // R2: a read fills the output register at the next edge
  a_r2_read_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RD) |=> valid_q);

  // R8: write or idle leaves an invalid marker
  a_r8_nonread_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_RD) |=> !dq_oe_o);
endmodule

// File: rtl/pipe_bw_sram.sv
module pipe_bw_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              chip_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [LANES-1:0]  byte_we_ni,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  op_e               op_q;
  logic [LANES-1:0]  lane_we_q;
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] rdata;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .proc_strb_ni(proc_strb_ni),
    .ctrl_strb_ni(ctrl_strb_ni),
    .chip_en_ni  (chip_en_ni),
    .addr_i      (addr_i),
    .din_i       (din_i),
    .byte_we_ni  (byte_we_ni),
    .addr_q_o    (addr_q),
    .op_q_o      (op_q),
    .lane_we_q_o (lane_we_q),
    .din_q_o     (din_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk_i    (clk_i),
    .we_i     (op_q == OP_WR),
    .lane_we_i(lane_we_q),
    .addr_i   (addr_q),
    .wdata_i  (din_q),
    .rdata_o  (rdata)
  );

  sram_outreg #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_q),
    .rdata_i  (rdata),
    .out_en_ni(out_en_ni),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o)
  );

  // R8: a registered write keeps the bus undriven
  a_r8_write_blocks_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_WR) |-> !dq_oe_o);

  // R7: output enable high always releases the bus
  a_r7_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !dq_oe_o);
endmodule

// File: tb/tb_pipe_bw_sram.sv
module tb_pipe_bw_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int NV     = 20;
  // {ps, cs, ce, be[1:0], oe, addr[7:0], din[17:0], exp_oe, exp_dq[17:0]}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'b00,1'b0,8'h10,18'h15A5A,1'b0,18'h00000}, // 0 write both lanes
    {1'b1,1'b0,1'b0,2'b00,1'b0,8'h20,18'h2C3C3,1'b0,18'h00000}, // 1 write
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h10,18'h00000,1'b0,18'h00000}, // 2 read after write: invalid
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h20,18'h00000,1'b1,18'h15A5A}, // 3 data of 2
    {1'b0,1'b1,1'b0,2'b00,1'b0,8'h10,18'h00000,1'b1,18'h2C3C3}, // 4 proc strobe ignores be
    {1'b1,1'b0,1'b0,2'b10,1'b0,8'h20,18'h3FFFF,1'b0,18'h00000}, // 5 lower lane write
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h20,18'h00000,1'b0,18'h00000}, // 6
    {1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h2C3FF}, // 7 held read
    {1'b1,1'b0,1'b1,2'b11,1'b0,8'h20,18'h00000,1'b1,18'h2C3FF}, // 8 deselect
    {1'b1,1'b1,1'b0,2'b00,1'b0,8'h20,18'h3FFFF,1'b0,18'h00000}, // 9 held deselect, no write
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h20,18'h00000,1'b0,18'h00000}, // 10
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h10,18'h00000,1'b1,18'h2C3FF}, // 11 unchanged by 9
    {1'b1,1'b1,1'b0,2'b11,1'b1,8'h55,18'h00000,1'b0,18'h00000}, // 12 oe high
    {1'b1,1'b0,1'b0,2'b01,1'b0,8'h10,18'h00000,1'b0,18'h00000}, // 13 upper lane write
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h10,18'h00000,1'b0,18'h00000}, // 14 read right after write
    {1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h0005A}, // 15
    {1'b0,1'b1,1'b0,2'b11,1'b0,8'h30,18'h00000,1'b1,18'h0005A}, // 16 two-cycle write, cycle 1
    {1'b1,1'b1,1'b0,2'b00,1'b0,8'h99,18'h12345,1'b0,18'h00000}, // 17 cycle 2, addr ignored
    {1'b1,1'b0,1'b0,2'b11,1'b0,8'h30,18'h00000,1'b0,18'h00000}, // 18
    {1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h00000,1'b1,18'h12345}  // 19
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps_n = 1'b1, cs_n = 1'b1, ce_n = 1'b1, oe_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [17:0] din = '0;
  logic [1:0] be_n = 2'b11;
  logic [17:0] dq;
  logic dq_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag [NV];

  always #(CLK_P/2) clk = ~clk;

  pipe_bw_sram #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .proc_strb_ni(ps_n), .ctrl_strb_ni(cs_n),
    .chip_en_ni(ce_n), .addr_i(addr), .din_i(din), .byte_we_ni(be_n),
    .out_en_ni(oe_n), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  task automatic check(input string t, input logic e_oe, input logic [17:0] e_dq);
    n_chk++;
    if (dq_oe !== e_oe || dq !== e_dq) begin
      n_bad++;
      $display("FAIL %s: oe=%0b dq=%05h expected oe=%0b dq=%05h", t, dq_oe, dq, e_oe, e_dq);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic cyc(input logic p, input logic c, input logic e, input logic [1:0] b,
                     input logic o, input logic [ADDR_W-1:0] a, input logic [17:0] d);
    ps_n = p; cs_n = c; ce_n = e; be_n = b; oe_n = o; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    tag = '{"R1 R6", "R1", "R8", "R1 R2", "R5", "R3 R8", "R8", "R3 R4", "R2",
            "R6", "R6", "R6", "R7 R11", "R8", "R8", "R3 R5 R10", "R2", "R4 R8",
            "R8", "R4"};
    #(CLK_P * 3 + 2);
    check("R9 reset holds bus released", 1'b0, 18'h0);
    check("R11 reset data zero", 1'b0, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 1'b0, 18'h0);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      cyc(v[50], v[49], v[48], v[47:46], v[45], v[44:37], v[36:19]);
      check(tag[i], v[18], v[17:0]);
    end

    // R7: asynchronous output enable, held read of 0x30
    cyc(1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 8'h30, 18'h0);
    check("R2 read 0x30", 1'b1, 18'h12345);
    oe_n = 1'b1; #1;
    check("R7 oe high releases without clock", 1'b0, 18'h0);
    oe_n = 1'b0; #1;
    check("R7 oe low drives without clock", 1'b1, 18'h12345);

    // R4: two-cycle write left 0x99 untouched; write it, then check 0x30 kept
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'h99, 18'h0ABCD);
    check("R8 write releases bus", 1'b0, 18'h0);
    cyc(1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 8'h30, 18'h0);
    cyc(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 18'h0);
    check("R4 held-address write hit only 0x30", 1'b1, 18'h12345);
    cyc(1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 8'h99, 18'h0);
    check("R1 write at 0x99 read back", 1'b1, 18'h12345);
    cyc(1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 8'h00, 18'h0);
    check("R1 data 0x99", 1'b1, 18'h0ABCD);

    // R9: reset while driving
    #1 rst_n = 1'b0; #1;
    check("R9 async reset releases bus", 1'b0, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 still released after reset", 1'b0, 18'h0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end
endmodule